// File: doc/BRIEF.md
# Unaligned Load Access Sequencer

This block turns a byte-addressed load of 1, 2 or 4 bytes into reads on a bus that only moves whole 32-bit words. A load whose bytes all fall in one word costs one bus read. A load that crosses into the next word costs two reads in back-to-back cycles: first the word that holds the start byte, then the word above it. The returned words are shifted and combined. The result is right-justified and zero-extended, with little-endian byte order.

A per-request mode input selects how misaligned loads are handled. With the mode clear, a misaligned load is served normally. With the mode set, the load issues no bus read and gets an alignment-fault response. Only one load is in flight at a time. The memory returns read data exactly one cycle after the read is issued.

Top module: `unaligned_load_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_en` are 0.
- R2: The word address on the bus is the byte address with its two low bits dropped. For a load that crosses a word boundary, the second read goes to that word address plus one, wrapping at the top of the address space.
- R3: A load whose bytes lie in one word issues exactly one read, in the cycle after acceptance. `rsp_valid` pulses for one cycle, two cycles after that read.
- R4: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. A load is misaligned if it is 2 or 4 bytes with address bit 0 set, or 4 bytes with address bit 1 set.
- R5: A load crosses a word boundary when its byte offset plus its byte count exceeds 4. This covers a 2-byte load at offset 3 and a 4-byte load at offsets 1 to 3. Such a load issues reads in two consecutive cycles, and the response follows two cycles after the second read.
- R6: The response data holds the byte at the start address in bits 7:0, followed by the next higher bytes. Bits above the access size are 0. A 2-byte load at offset 1 is served from one word.
- R7: When `fault_en` is 1 at acceptance and the load is misaligned, no read is issued. In the next cycle `rsp_valid` and `rsp_fault` are 1 and `rsp_data` is 0.
- R8: When `fault_en` is 0, misaligned loads complete with correct data and `rsp_fault` is 0. Aligned loads never fault, whatever the value of `fault_en`.
- R9: `req_ready` is 0 from the cycle after acceptance through the response cycle. A `req_valid` seen in that window is not accepted.
- R10: Read data is taken from `mem_rd_data` exactly one cycle after the cycle in which `mem_rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 32 | Byte address of the load |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| fault_en | input | 1 | 1 = fault on misaligned loads, 0 = split them |
| mem_rd_en | output | 1 | Word read strobe |
| mem_word_addr | output | 30 | Word address of the read |
| mem_rd_data | input | 32 | Read word, valid one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Right-justified, zero-extended load result |
| rsp_fault | output | 1 | Alignment fault reported with the response |

## Verification
Several rules are checked by assertions on every cycle:
- the response is a single-cycle pulse and a faulting response carries zero data;
- no new request is accepted while a load is in flight;
- two back-to-back reads always target consecutive words;
- a faulted load makes no bus read, and every data response is preceded by a read two cycles earlier.

The byte merging and zero-extension, the exact boundary between one-word and two-word loads, and wrap-around at the top of memory can only be shown by the bench scenarios. Each scenario is compared against a behavioural per-cycle model.

// File: rtl/unaligned_load_seq.sv
module unaligned_load_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              fault_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-3:0] mem_word_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_fault
);
  localparam int WA_W = ADDR_W - 2;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_CAP, S_RSP, S_FLT} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [31:0]       first_q, result_q;

  logic              accept, in_misal;
  logic [1:0]        off;
  logic [2:0]        nbytes;
  logic              split;
  logic [63:0]       pair, shifted;
  logic [31:0]       mask;

  assign accept   = req_valid && req_ready;
  assign in_misal = (req_size != 2'd0 && req_addr[0]) || (req_size[1] && req_addr[1]);

  assign off    = addr_q[1:0];
  assign nbytes = (size_q == 2'd0) ? 3'd1 : (size_q == 2'd1) ? 3'd2 : 3'd4;
  assign split  = ({1'b0, off} + nbytes) > 3'd4;

  assign pair    = {mem_rd_data, split ? first_q : mem_rd_data};
  assign shifted = pair >> {off, 3'b000};
  assign mask    = (size_q == 2'd0) ? 32'h0000_00FF :
                   (size_q == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  assign req_ready     = (state == S_IDLE);
  assign mem_rd_en     = (state == S_RD1) || (state == S_RD2);
  assign mem_word_addr = addr_q[ADDR_W-1:2] + WA_W'(state == S_RD2);
  assign rsp_valid     = (state == S_RSP) || (state == S_FLT);
  assign rsp_fault     = (state == S_FLT);
  assign rsp_data      = (state == S_RSP) ? result_q : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      size_q   <= '0;
      first_q  <= '0;
      result_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          addr_q <= req_addr;
          size_q <= req_size;
          state  <= (fault_en && in_misal) ? S_FLT : S_RD1;
        end
        S_RD1: state <= split ? S_RD2 : S_CAP;
        S_RD2: begin
          first_q <= mem_rd_data;
          state   <= S_CAP;
        end
        S_CAP: begin
          result_q <= shifted[31:0] & mask;
          state    <= S_RSP;
        end
        S_RSP:   state <= S_IDLE;
        S_FLT:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_fault_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_data == 32'h0));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_next_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_word_addr == $past(mem_word_addr) + 1'b1));

  p_fault_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && fault_en &&
     ((req_size != 2'd0 && req_addr[0]) || (req_size[1] && req_addr[1])))
    |=> (rsp_valid && rsp_fault && !mem_rd_en));

  p_data_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> $past(mem_rd_en, 2));
endmodule

// File: tb/unaligned_load_seq_bench.sv
module unaligned_load_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        fault_en = 1'b0;
  logic        mem_rd_en;
  logic [29:0] mem_word_addr;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_fault;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  unaligned_load_seq u_unaligned_load_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .fault_en(fault_en),
    .mem_rd_en(mem_rd_en), .mem_word_addr(mem_word_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault));

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'(int'(a[5:0]) * 37 + 11);
  endfunction

  function automatic logic [31:0] mword(input logic [29:0] k);
    return {mbyte({k, 2'd3}), mbyte({k, 2'd2}), mbyte({k, 2'd1}), mbyte({k, 2'd0})};
  endfunction

  // R10: memory answers exactly one cycle after the strobe
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mword(mem_word_addr);

  typedef struct {
    bit          rd;
    logic [29:0] wa;
    bit          rv;
    bit          flt;
    logic [31:0] d;
  } exp_t;
  exp_t q[$];

  function automatic exp_t mk(bit rd, logic [29:0] wa, bit rv, bit flt, logic [31:0] d);
    exp_t e;
    e.rd = rd; e.wa = wa; e.rv = rv; e.flt = flt; e.d = d;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      bit acc;
      acc = req_valid && (q.size() == 0);
      if (q.size() != 0) void'(q.pop_front());
      if (acc) begin
        int nb, off;
        bit mis;
        logic [31:0] d;
        logic [29:0] w;
        nb  = (req_size == 0) ? 1 : (req_size == 1) ? 2 : 4;
        off = int'(req_addr[1:0]);
        mis = (nb >= 2 && req_addr[0]) || (nb == 4 && req_addr[1]);
        w   = req_addr[31:2];
        d   = 0;
        for (int i = 0; i < nb; i++) d[8*i +: 8] = mbyte(req_addr + 32'(i));
        if (fault_en && mis) begin
          q.push_back(mk(0, 0, 1, 1, 0));
        end else if (off + nb > 4) begin
          q.push_back(mk(1, w, 0, 0, 0));
          q.push_back(mk(1, w + 30'd1, 0, 0, 0));
          q.push_back(mk(0, 0, 0, 0, 0));
          q.push_back(mk(0, 0, 1, 0, d));
        end else begin
          q.push_back(mk(1, w, 0, 0, 0));
          q.push_back(mk(0, 0, 0, 0, 0));
          q.push_back(mk(0, 0, 1, 0, d));
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      exp_t e;
      e = (q.size() != 0) ? q[0] : mk(0, 0, 0, 0, 0);
      chk("R9 req_ready", 32'(req_ready), 32'(q.size() == 0));
      chk("R3 R5 R7 mem_rd_en", 32'(mem_rd_en), 32'(e.rd));
      if (e.rd) chk("R2 mem_word_addr", 32'(mem_word_addr), 32'(e.wa));
      chk("R3 rsp_valid", 32'(rsp_valid), 32'(e.rv));
      if (e.rv) begin
        chk("R7 R8 rsp_fault", 32'(rsp_fault), 32'(e.flt));
        chk("R4 R5 R6 R10 rsp_data", rsp_data, e.d);
      end
    end
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic load(input logic [31:0] a, input logic [1:0] s, input logic fe);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; fault_en = fe;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0100; bases[1] = 32'h0000_003C;
    bases[2] = 32'h8000_0020; bases[3] = 32'hFFFF_FFFC;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_rd_en", 32'(mem_rd_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R7 R8: every size code, offset and mode at several bases, top-of-memory wrap included
    for (int b = 0; b < 4; b++)
      for (int fe = 0; fe < 2; fe++)
        for (int s = 0; s < 4; s++)
          for (int o = 0; o < 4; o++)
            load(bases[b] + 32'(o), 2'(s), 1'(fe));
    drain();

    // R9: requests held while busy are not taken
    load(32'h0000_0201, 2'd2, 1'b0);
    req_valid = 1'b1; req_addr = 32'h0000_0300; req_size = 2'd0;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    drain();

    // R6: 2-byte load at offset 1 stays inside one word
    load(32'h0000_0011, 2'd1, 1'b0);
    drain();
    // R7: same load faults in fault mode
    load(32'h0000_0011, 2'd1, 1'b1);
    drain();
    // back-to-back faulted and split loads
    load(32'h0000_0013, 2'd2, 1'b1);
    load(32'h0000_0013, 2'd2, 1'b0);
    drain();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule